// File: doc/BRIEF.md
# Register-Pair Split Sequencer

This block sits in the decode pipeline and expands each 16-byte load or store into two 8-byte micro-operations. Each micro-operation addresses one register of an even/odd register pair. Ordinary operations pass through unchanged as a single micro-operation. Each outgoing micro-operation carries two tags:

- **repeat** marks both halves of a split operation.
- **second** marks only the later half.

Later stages use these tags to hold off asynchronous interrupts on the second half and to step the address up by 8 bytes, so that memory is visited in rising address order.

The endianness flag decides which register of the pair the first half uses. Operand combinations that would corrupt state are caught here: a 16-byte load whose base register is also its destination, and an atomic 16-byte load whose base or index register is its destination. Such an operation leaves as one micro-operation with an illegal tag and is not repeated.

Both sides use a valid/ready handshake. The output is registered. A synchronous flush drops whatever is held, including a pending second half.

Top module: `pair_split_seq`

## Requirements
- R1: An operation of class 2'b00 or 2'b11 (plain) yields one micro-operation. Its register field equals the incoming target register, and its repeat, second and illegal tags are 0.
- R2: A legal operation of class 2'b01 (16-byte load) or 2'b10 (16-byte store) yields exactly two consecutive micro-operations. Both carry repeat=1. The first carries second=0 and the next carries second=1. Class, base, index and atomic fields are identical in both.
- R3: With the little-endian flag at 1, the first half's register is the target with bit 0 forced to 1, and the second half's register is the target with bit 0 forced to 0.
- R4: With the little-endian flag at 0, the first half uses bit 0 forced to 0 and the second half uses bit 0 forced to 1.
- R5: A 16-byte load whose base register equals its target register yields a single micro-operation with illegal=1, repeat=0, second=0 and the register field unchanged.
- R6: An atomic 16-byte load whose index register equals its target is also illegal, as in R5. The same index match on a non-atomic load is legal. A 16-byte store is never illegal.
- R7: Input ready is 0 while a second half is pending. While output valid is 1 and output ready is 0, every output field is held unchanged.
- R8: A cycle with flush at 1 drives input ready to 0, accepts nothing, and leaves output valid at 0 in the following cycle with no pending second half.
- R9: After reset, output valid is 0 and input ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard held and pending micro-operations |
| in_valid | input | 1 | Incoming operation valid |
| in_ready | output | 1 | Sequencer can accept an operation |
| in_cls | input | 2 | Operation class: 00/11 plain, 01 16-byte load, 10 16-byte store |
| in_rt | input | REG_W | Target/source data register |
| in_ra | input | REG_W | Base register |
| in_rb | input | REG_W | Index register |
| in_atomic | input | 1 | Reserve/atomic form |
| in_little | input | 1 | Little-endian mode |
| out_valid | output | 1 | Micro-operation valid |
| out_ready | input | 1 | Consumer accepts micro-operation |
| out_cls | output | 2 | Class of the micro-operation |
| out_reg | output | REG_W | Adjusted data register |
| out_ra | output | REG_W | Base register |
| out_rb | output | REG_W | Index register |
| out_atomic | output | 1 | Atomic form |
| out_repeat | output | 1 | Part of a split operation |
| out_second | output | 1 | Second half of a split operation |
| out_illegal | output | 1 | Illegal register combination |

## Verification
An accepted operation appears on the output ports one clock edge after the edge that accepted it. With output ready high, the second half replaces the first on the following edge. The bench drives inputs on the falling edge and samples one and two falling edges after acceptance, so every check lands in the cycle the registered output is due.

During a stall, the bench samples over several falling edges to confirm the held value and the low input ready. A flush takes effect at the next rising edge, so output valid is checked at the following falling edge.

// File: rtl/pair_seq_pkg.sv
package pair_seq_pkg;

  typedef enum logic [1:0] {
    CLS_PLAIN  = 2'b00,
    CLS_QLOAD  = 2'b01,
    CLS_QSTORE = 2'b10,
    CLS_PLAIN2 = 2'b11
  } op_cls_e;

endpackage

// File: rtl/pair_seq_legality.sv
module pair_seq_legality #(
  parameter int REG_W = 5
) (
  input  logic [1:0]       cls,
  input  logic             atomic,
  input  logic [REG_W-1:0] rt,
  input  logic [REG_W-1:0] ra,
  input  logic [REG_W-1:0] rb,
  output logic             is_quad,
  output logic             illegal
);
  import pair_seq_pkg::*;

  logic is_qload;
  logic base_clash;
  logic index_clash;

  always_comb begin
    is_qload    = (cls == CLS_QLOAD);
    is_quad     = (cls == CLS_QLOAD) || (cls == CLS_QSTORE);
    base_clash  = (ra == rt);
    index_clash = (rb == rt);
    illegal     = is_qload && (base_clash || (atomic && index_clash));
  end

endmodule

// File: rtl/pair_seq_regsel.sv
module pair_seq_regsel #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] rt,
  input  logic             little,
  output logic [REG_W-1:0] first_reg,
  output logic [REG_W-1:0] second_reg
);
  logic [REG_W-1:0] odd_reg;
  logic [REG_W-1:0] even_reg;

  always_comb begin
    odd_reg    = {rt[REG_W-1:1], 1'b1};
    even_reg   = {rt[REG_W-1:1], 1'b0};
    first_reg  = little ? odd_reg  : even_reg;
    second_reg = little ? even_reg : odd_reg;
  end

endmodule

// File: rtl/pair_seq_core.sv
module pair_seq_core #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_cls,
  input  logic [REG_W-1:0] in_ra,
  input  logic [REG_W-1:0] in_rb,
  input  logic             in_atomic,
  input  logic [REG_W-1:0] plain_reg,
  input  logic [REG_W-1:0] first_reg,
  input  logic [REG_W-1:0] second_reg,
  input  logic             is_quad,
  input  logic             illegal,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_cls,
  output logic [REG_W-1:0] out_reg,
  output logic [REG_W-1:0] out_ra,
  output logic [REG_W-1:0] out_rb,
  output logic             out_atomic,
  output logic             out_repeat,
  output logic             out_second,
  output logic             out_illegal
);
  logic             vld_q;
  logic             pend_q;
  logic [REG_W-1:0] saved_q;
  logic             split;
  logic             accept;

  assign split    = is_quad && !illegal;
  assign in_ready = !flush && !pend_q && (!vld_q || out_ready);
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q       <= 1'b0;
      pend_q      <= 1'b0;
      saved_q     <= '0;
      out_cls     <= '0;
      out_reg     <= '0;
      out_ra      <= '0;
      out_rb      <= '0;
      out_atomic  <= 1'b0;
      out_repeat  <= 1'b0;
      out_second  <= 1'b0;
      out_illegal <= 1'b0;
    end else if (flush) begin
      vld_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (accept) begin
      vld_q       <= 1'b1;
      pend_q      <= split;
      saved_q     <= second_reg;
      out_cls     <= in_cls;
      out_reg     <= split ? first_reg : plain_reg;
      out_ra      <= in_ra;
      out_rb      <= in_rb;
      out_atomic  <= in_atomic;
      out_repeat  <= split;
      out_second  <= 1'b0;
      out_illegal <= illegal;
    end else if (vld_q && out_ready) begin
      if (pend_q) begin
        out_reg    <= saved_q;
        out_second <= 1'b1;
        pend_q     <= 1'b0;
      end else begin
        vld_q <= 1'b0;
      end
    end
  end

  assign out_valid = vld_q;

  // R7: a stalled micro-operation does not change
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !flush) |=>
      (out_valid && $stable(out_reg) && $stable(out_second) && $stable(out_cls)));

  // R7: nothing new enters while a first half waits for its partner
  p_block_input_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_repeat && !out_second) |-> !in_ready);

  // R2: a consumed first half is followed at once by its second half
  p_second_follows_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_repeat && !out_second && !flush) |=>
      (out_valid && out_second && out_repeat));

  // R3 R4: the two halves address opposite registers of the pair
  p_pair_flip_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_repeat && !out_second && !flush) |=>
      (out_reg[0] != $past(out_reg[0])));

  // R5: illegal forms are never repeated
  p_illegal_single_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (!out_repeat && !out_second));

  // R8: flush empties the output register
  p_flush_clear_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> !out_valid);

endmodule

// File: rtl/pair_split_seq.sv
module pair_split_seq #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_cls,
  input  logic [REG_W-1:0] in_rt,
  input  logic [REG_W-1:0] in_ra,
  input  logic [REG_W-1:0] in_rb,
  input  logic             in_atomic,
  input  logic             in_little,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_cls,
  output logic [REG_W-1:0] out_reg,
  output logic [REG_W-1:0] out_ra,
  output logic [REG_W-1:0] out_rb,
  output logic             out_atomic,
  output logic             out_repeat,
  output logic             out_second,
  output logic             out_illegal
);
  logic             is_quad;
  logic             illegal;
  logic [REG_W-1:0] first_reg;
  logic [REG_W-1:0] second_reg;

  pair_seq_legality #(.REG_W(REG_W)) u_legal (
    .cls     (in_cls),
    .atomic  (in_atomic),
    .rt      (in_rt),
    .ra      (in_ra),
    .rb      (in_rb),
    .is_quad (is_quad),
    .illegal (illegal)
  );

  pair_seq_regsel #(.REG_W(REG_W)) u_regsel (
    .rt         (in_rt),
    .little     (in_little),
    .first_reg  (first_reg),
    .second_reg (second_reg)
  );

  pair_seq_core #(.REG_W(REG_W)) u_core (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_cls      (in_cls),
    .in_ra       (in_ra),
    .in_rb       (in_rb),
    .in_atomic   (in_atomic),
    .plain_reg   (in_rt),
    .first_reg   (first_reg),
    .second_reg  (second_reg),
    .is_quad     (is_quad),
    .illegal     (illegal),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_cls     (out_cls),
    .out_reg     (out_reg),
    .out_ra      (out_ra),
    .out_rb      (out_rb),
    .out_atomic  (out_atomic),
    .out_repeat  (out_repeat),
    .out_second  (out_second),
    .out_illegal (out_illegal)
  );

endmodule

// File: tb/pair_split_seq_tb.sv
module pair_split_seq_tb;
  localparam int REG_W = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             flush = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [1:0]       in_cls = 2'b00;
  logic [REG_W-1:0] in_rt = '0;
  logic [REG_W-1:0] in_ra = '0;
  logic [REG_W-1:0] in_rb = '0;
  logic             in_atomic = 1'b0;
  logic             in_little = 1'b0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [1:0]       out_cls;
  logic [REG_W-1:0] out_reg;
  logic [REG_W-1:0] out_ra;
  logic [REG_W-1:0] out_rb;
  logic             out_atomic;
  logic             out_repeat;
  logic             out_second;
  logic             out_illegal;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pair_split_seq #(.REG_W(REG_W)) u_dut (
    .clk(clk), .rst(rst), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_cls(in_cls),
    .in_rt(in_rt), .in_ra(in_ra), .in_rb(in_rb),
    .in_atomic(in_atomic), .in_little(in_little),
    .out_valid(out_valid), .out_ready(out_ready), .out_cls(out_cls),
    .out_reg(out_reg), .out_ra(out_ra), .out_rb(out_rb),
    .out_atomic(out_atomic), .out_repeat(out_repeat),
    .out_second(out_second), .out_illegal(out_illegal)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Uop: valid, reg, repeat, second, illegal
  task automatic check_uop(input string req, input int reg_e, input int rep_e,
                           input int sec_e, input int ill_e);
    check(req, "out_valid", int'(out_valid), 1);
    check(req, "out_reg", int'(out_reg), reg_e);
    check(req, "out_repeat", int'(out_repeat), rep_e);
    check(req, "out_second", int'(out_second), sec_e);
    check(req, "out_illegal", int'(out_illegal), ill_e);
  endtask

  // Present one operation at a falling edge, expect it accepted at the next rise
  task automatic push(input logic [1:0] cls, input int rt, input int ra, input int rb,
                      input logic atomic, input logic little);
    @(negedge clk);
    in_cls = cls; in_rt = REG_W'(rt); in_ra = REG_W'(ra); in_rb = REG_W'(rb);
    in_atomic = atomic; in_little = little; in_valid = 1'b1;
    check("R7", "in_ready before push", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset_r9;
    check("R9", "out_valid after reset", int'(out_valid), 0);
    check("R9", "in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_plain_r1;
    push(2'b00, 13, 13, 2, 1'b0, 1'b1);
    check_uop("R1", 13, 0, 0, 0);
    @(negedge clk);
    check("R1", "single uop then idle", int'(out_valid), 0);
    push(2'b11, 4, 1, 2, 1'b0, 1'b0);
    check_uop("R1", 4, 0, 0, 0);
    @(negedge clk);
  endtask

  task automatic t_quad_le_r3;
    push(2'b01, 6, 3, 4, 1'b0, 1'b1);
    check_uop("R3", 7, 1, 0, 0);
    check("R7", "in_ready with half pending", int'(in_ready), 0);
    @(negedge clk);
    check_uop("R3", 6, 1, 1, 0);
    check("R2", "out_ra same", int'(out_ra), 3);
    check("R2", "out_cls same", int'(out_cls), 1);
    @(negedge clk);
    check("R2", "exactly two uops", int'(out_valid), 0);
    push(2'b10, 9, 9, 9, 1'b1, 1'b1);
    check_uop("R3", 9, 1, 0, 0);
    @(negedge clk);
    check_uop("R6", 8, 1, 1, 0);
    check("R2", "out_atomic same", int'(out_atomic), 1);
    @(negedge clk);
  endtask

  task automatic t_quad_be_r4;
    push(2'b01, 6, 3, 4, 1'b0, 1'b0);
    check_uop("R4", 6, 1, 0, 0);
    @(negedge clk);
    check_uop("R4", 7, 1, 1, 0);
    push(2'b10, 9, 1, 1, 1'b0, 1'b0);
    check_uop("R4", 8, 1, 0, 0);
    @(negedge clk);
    check_uop("R4", 9, 1, 1, 0);
    @(negedge clk);
  endtask

  task automatic t_illegal_r5_r6;
    push(2'b01, 10, 10, 2, 1'b0, 1'b1);
    check_uop("R5", 10, 0, 0, 1);
    @(negedge clk);
    check("R5", "no repetition", int'(out_valid), 0);
    push(2'b01, 12, 3, 12, 1'b1, 1'b0);
    check_uop("R6", 12, 0, 0, 1);
    @(negedge clk);
    push(2'b01, 12, 3, 12, 1'b0, 1'b0);
    check_uop("R6", 12, 1, 0, 0);
    @(negedge clk);
    check_uop("R6", 13, 1, 1, 0);
    @(negedge clk);
  endtask

  task automatic t_backpressure_r7;
    out_ready = 1'b0;
    push(2'b01, 20, 1, 2, 1'b0, 1'b1);
    in_cls = 2'b00; in_rt = 5'd3; in_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      check_uop("R7", 21, 1, 0, 0);
      check("R7", "in_ready during stall", int'(in_ready), 0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check_uop("R7", 20, 1, 1, 0);
    check("R7", "in_ready after second shown", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    check_uop("R7", 3, 0, 0, 0);
    @(negedge clk);
  endtask

  task automatic t_flush_r8;
    out_ready = 1'b0;
    push(2'b10, 16, 1, 2, 1'b0, 1'b0);
    check_uop("R8", 16, 1, 0, 0);
    flush = 1'b1;
    in_cls = 2'b00; in_rt = 5'd5; in_valid = 1'b1;
    check("R8", "in_ready during flush", int'(in_ready), 0);
    @(negedge clk);
    flush = 1'b0; in_valid = 1'b0;
    check("R8", "out_valid after flush", int'(out_valid), 0);
    out_ready = 1'b1;
    @(negedge clk);
    check("R8", "no stale second half", int'(out_valid), 0);
    push(2'b00, 2, 0, 0, 1'b0, 1'b0);
    check_uop("R8", 2, 0, 0, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_r9();
    t_plain_r1();
    t_quad_le_r3();
    t_quad_be_r4();
    t_illegal_r5_r6();
    t_backpressure_r7();
    t_flush_r8();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #200000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule